// File: doc/BRIEF.md
# Single-Requester Bus Region Router

This block sits between the one requester of an AHB-Lite bus and three completer slots: main RAM at the bottom of the physical map, a small GPIO register bank, and a boot RAM placed where the first instruction fetch after reset lands. All addresses it sees are physical addresses. There is only one requester, so no arbitration logic is present. In the address phase it decodes the address combinationally and raises the select line of the slot that owns the address. When the bus is ready it records which slot owns the transfer. In the data phase, read data, ready and response then come from that slot.

Addresses that no slot owns are served by a built-in default completer. An active transfer to such an address gets the standard two-cycle ERROR response. Idle and busy transfers to any address complete at once with OKAY. The RAM window size is a parameter: a power of two from 32 KB to 256 KB. Addresses inside the RAM range that lie beyond the configured size count as unmapped.

Top module: `bus_region_router`

## Requirements
- R1: After reset, with no transfer in progress, hready reads 1, hresp reads 0 (OKAY) and hrdata reads 0.
- R2: An address below RAM_BYTES (default 32768) raises hsel_ram only. RAM_BYTES must be a power of two between 32 KB and 256 KB.
- R3: Addresses 0x1F800000 to 0x1F800013 raise hsel_io only. 0x1F800014 raises no select.
- R4: Addresses 0x1FC00000 to 0x1FC00FFF raise hsel_boot only.
- R5: At most one select is high at any time. An address outside every window, including RAM addresses at or above RAM_BYTES, raises none.
- R6: When an active transfer (htrans 2'b10 NONSEQ or 2'b11 SEQ) is accepted with hready high, then in the following cycles, until hready is next high, hrdata, hready and hresp equal the selected slot's read data, ready and response inputs.
- R7: While hready is low, the recorded slot does not change, whatever haddr and htrans do.
- R8: A transfer with htrans 2'b00 (IDLE) or 2'b01 (BUSY) that is accepted with hready high gets, in the next cycle, hready 1, hresp 0 and hrdata 0. This holds even at an unmapped address.
- R9: An active transfer to an unmapped address gets hready 0 with hresp 1 in the next cycle, then hready 1 with hresp 1 in the cycle after that. hrdata is 0 in both cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| haddr | input | 32 | Physical address from the requester |
| htrans | input | 2 | Transfer type (IDLE, BUSY, NONSEQ, SEQ) |
| ram_hrdata | input | 32 | Read data from the main RAM slot |
| ram_hreadyout | input | 1 | Ready from the main RAM slot |
| ram_hresp | input | 1 | Response from the main RAM slot |
| io_hrdata | input | 32 | Read data from the GPIO slot |
| io_hreadyout | input | 1 | Ready from the GPIO slot |
| io_hresp | input | 1 | Response from the GPIO slot |
| boot_hrdata | input | 32 | Read data from the boot RAM slot |
| boot_hreadyout | input | 1 | Ready from the boot RAM slot |
| boot_hresp | input | 1 | Response from the boot RAM slot |
| hsel_ram | output | 1 | Address-phase select for main RAM |
| hsel_io | output | 1 | Address-phase select for GPIO |
| hsel_boot | output | 1 | Address-phase select for boot RAM |
| hrdata | output | 32 | Read data to the requester |
| hready | output | 1 | Bus ready, to the requester and to every slot |
| hresp | output | 1 | Response to the requester |

## Verification
The select lines follow haddr within the same cycle. The bench therefore drives the address half a cycle before a clock edge and reads the selects one time step later. The data-phase outputs belong to the transfer accepted at the previous rising edge on which hready was high. An ERROR takes two such cycles, and a stalled slot stretches the data phase for as long as it holds ready low. A behavioural model in the bench records the accepted slot and the error step at each edge. It predicts all six outputs for the coming cycle, and they are compared once per cycle at the same sampling point.

// File: rtl/brr_pkg.sv
package brr_pkg;

  localparam int NSLOT = 3;

  typedef enum logic [1:0] {
    SLOT_RAM  = 2'd0,
    SLOT_IO   = 2'd1,
    SLOT_BOOT = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input logic [32:0] bytes);
    logic [32:0] lo;
    lo = {1'b0, base};
    return ({1'b0, a} >= lo) && ({1'b0, a} < (lo + bytes));
  endfunction

endpackage

// File: rtl/brr_decode.sv
module brr_decode
  import brr_pkg::*;
#(
  parameter int unsigned RAM_BYTES  = 32768,
  parameter logic [31:0] IO_BASE    = 32'h1F80_0000,
  parameter int unsigned IO_BYTES   = 20,
  parameter logic [31:0] BOOT_BASE  = 32'h1FC0_0000,
  parameter int unsigned BOOT_BYTES = 4096
) (
  input  logic [31:0]      haddr,
  output logic [NSLOT-1:0] hit,
  output slot_e            slot
);

  localparam logic [31:0] BASES [NSLOT] = '{32'h0000_0000, IO_BASE, BOOT_BASE};
  localparam logic [32:0] SIZES [NSLOT] = '{33'(RAM_BYTES), 33'(IO_BYTES), 33'(BOOT_BYTES)};

  initial begin
    a_r2_ram_size_legal: assert (RAM_BYTES >= 32768 && RAM_BYTES <= 262144 &&
                                 (RAM_BYTES & (RAM_BYTES - 1)) == 0)
      else $error("RAM_BYTES must be a power of two in 32K..256K");
    a_r5_windows_disjoint: assert (33'(RAM_BYTES) <= {1'b0, IO_BASE} &&
                                   {1'b0, IO_BASE} + 33'(IO_BYTES) <= {1'b0, BOOT_BASE})
      else $error("address windows overlap");
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_win
    assign hit[g] = in_window(haddr, BASES[g], SIZES[g]);
  end

  always_comb begin
    slot = SLOT_NONE;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (hit[i]) slot = slot_e'(2'(i));
    end
  end

endmodule

// File: rtl/brr_default_resp.sv
module brr_default_resp (
  input  logic clk,
  input  logic rst,
  input  logic hready,
  input  logic take_err,
  output logic dflt_ready,
  output logic dflt_resp
);

  logic err_first, err_second;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_first  <= 1'b0;
      err_second <= 1'b0;
    end else begin
      err_first  <= hready && take_err;
      err_second <= err_first;
    end
  end

  assign dflt_ready = !err_first;
  assign dflt_resp  = err_first || err_second;

  a_r9_second_cycle: assert property (@(posedge clk) disable iff (rst)
    err_first |=> (dflt_ready && dflt_resp));

endmodule

// File: rtl/brr_resp_mux.sv
module brr_resp_mux
  import brr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        active,
  input  slot_e       slot_d,
  input  logic [31:0] s_rdata [NSLOT],
  input  logic        s_ready [NSLOT],
  input  logic        s_resp  [NSLOT],
  input  logic        dflt_ready,
  input  logic        dflt_resp,
  output logic [31:0] hrdata,
  output logic        hready,
  output logic        hresp
);

  slot_e slot_q;

  always_ff @(posedge clk) begin
    if (rst)         slot_q <= SLOT_NONE;
    else if (hready) slot_q <= active ? slot_d : SLOT_NONE;
  end

  always_comb begin
    hrdata = 32'h0;
    hready = dflt_ready;
    hresp  = dflt_resp;
    if (slot_q != SLOT_NONE) begin
      hrdata = s_rdata[slot_q];
      hready = s_ready[slot_q];
      hresp  = s_resp[slot_q];
    end
  end

  a_r7_hold_in_wait: assert property (@(posedge clk) disable iff (rst)
    !hready |=> $stable(slot_q));

endmodule

// File: rtl/bus_region_router.sv
module bus_region_router
  import brr_pkg::*;
#(
  parameter int unsigned RAM_BYTES  = 32768,
  parameter logic [31:0] IO_BASE    = 32'h1F80_0000,
  parameter int unsigned IO_BYTES   = 20,
  parameter logic [31:0] BOOT_BASE  = 32'h1FC0_0000,
  parameter int unsigned BOOT_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] haddr,
  input  logic [1:0]  htrans,
  input  logic [31:0] ram_hrdata,
  input  logic        ram_hreadyout,
  input  logic        ram_hresp,
  input  logic [31:0] io_hrdata,
  input  logic        io_hreadyout,
  input  logic        io_hresp,
  input  logic [31:0] boot_hrdata,
  input  logic        boot_hreadyout,
  input  logic        boot_hresp,
  output logic        hsel_ram,
  output logic        hsel_io,
  output logic        hsel_boot,
  output logic [31:0] hrdata,
  output logic        hready,
  output logic        hresp
);

  logic [NSLOT-1:0] hit;
  slot_e            slot_d;
  logic             active;
  logic             dflt_ready, dflt_resp;
  logic [31:0]      s_rdata [NSLOT];
  logic             s_ready [NSLOT];
  logic             s_resp  [NSLOT];

  assign active = (htrans == TR_NONSEQ) || (htrans == TR_SEQ);

  brr_decode #(
    .RAM_BYTES(RAM_BYTES), .IO_BASE(IO_BASE), .IO_BYTES(IO_BYTES),
    .BOOT_BASE(BOOT_BASE), .BOOT_BYTES(BOOT_BYTES)
  ) u_dec (
    .haddr(haddr), .hit(hit), .slot(slot_d)
  );

  assign hsel_ram  = hit[SLOT_RAM];
  assign hsel_io   = hit[SLOT_IO];
  assign hsel_boot = hit[SLOT_BOOT];

  assign s_rdata = '{ram_hrdata, io_hrdata, boot_hrdata};
  assign s_ready = '{ram_hreadyout, io_hreadyout, boot_hreadyout};
  assign s_resp  = '{ram_hresp, io_hresp, boot_hresp};

  brr_default_resp u_dflt (
    .clk(clk), .rst(rst), .hready(hready),
    .take_err(active && (slot_d == SLOT_NONE)),
    .dflt_ready(dflt_ready), .dflt_resp(dflt_resp)
  );

  brr_resp_mux u_mux (
    .clk(clk), .rst(rst), .active(active), .slot_d(slot_d),
    .s_rdata(s_rdata), .s_ready(s_ready), .s_resp(s_resp),
    .dflt_ready(dflt_ready), .dflt_resp(dflt_resp),
    .hrdata(hrdata), .hready(hready), .hresp(hresp)
  );

  a_r1_reset_okay: assert property (@(posedge clk)
    rst |=> (hready && !hresp && hrdata == 32'h0));

  a_r5_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hsel_ram, hsel_io, hsel_boot}));

  a_r8_idle_zero_wait: assert property (@(posedge clk) disable iff (rst)
    (hready && !active) |=> (hready && !hresp));

  a_r9_first_cycle: assert property (@(posedge clk) disable iff (rst)
    (hready && active && !hsel_ram && !hsel_io && !hsel_boot) |=> (!hready && hresp));

  a_r6_ram_forward: assert property (@(posedge clk) disable iff (rst)
    (hready && active && hsel_ram) |=> (hrdata == ram_hrdata && hready == ram_hreadyout));

endmodule

// File: tb/sim_bus_region_router.sv
`timescale 1ns/1ps
module sim_bus_region_router;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] haddr = 32'h0;
  logic [1:0]  htrans = 2'b00;
  logic [2:0]  s_rdy = 3'b111;
  logic [2:0]  s_rsp = 3'b000;
  logic [31:0] cyc = 32'h0;
  logic        hsel_ram, hsel_io, hsel_boot, hready, hresp;
  logic [31:0] hrdata;
  int          checks = 0;
  int          fails = 0;

  // model state: 0 ram, 1 io, 2 boot, 3 none; err step 0/1/2
  int m_slot = 3;
  int m_err  = 0;

  always #2.5 clk = ~clk;

  bus_region_router u0 (
    .clk(clk), .rst(rst), .haddr(haddr), .htrans(htrans),
    .ram_hrdata(32'hA000_0000 ^ cyc), .ram_hreadyout(s_rdy[0]), .ram_hresp(s_rsp[0]),
    .io_hrdata(32'hB000_0000 ^ cyc), .io_hreadyout(s_rdy[1]), .io_hresp(s_rsp[1]),
    .boot_hrdata(32'hC000_0000 ^ cyc), .boot_hreadyout(s_rdy[2]), .boot_hresp(s_rsp[2]),
    .hsel_ram(hsel_ram), .hsel_io(hsel_io), .hsel_boot(hsel_boot),
    .hrdata(hrdata), .hready(hready), .hresp(hresp)
  );

  function automatic int owner(input logic [31:0] a);
    if (a < 32'd32768) return 0;
    if (a >= 32'h1F80_0000 && a <= 32'h1F80_0013) return 1;
    if (a >= 32'h1FC0_0000 && a <= 32'h1FC0_0FFF) return 2;
    return 3;
  endfunction

  task automatic step(input logic [31:0] a, input logic [1:0] t,
                      input logic [2:0] rdy, input logic [2:0] rsp, input string tag);
    int          own, nerr;
    logic [2:0]  e_sel;
    logic        e_rdy, e_rsp;
    logic [31:0] e_dat;
    @(negedge clk);
    haddr = a; htrans = t; s_rdy = rdy; s_rsp = rsp; cyc = cyc + 1;
    #1;
    own   = owner(a);
    e_sel = (own == 3) ? 3'b000 : 3'(1 << own);
    if (m_slot == 3) begin
      e_rdy = (m_err != 1); e_rsp = (m_err != 0); e_dat = 32'h0;
    end else begin
      e_rdy = rdy[m_slot]; e_rsp = rsp[m_slot];
      e_dat = (m_slot == 0) ? (32'hA000_0000 ^ cyc) :
              (m_slot == 1) ? (32'hB000_0000 ^ cyc) : (32'hC000_0000 ^ cyc);
    end
    checks++;
    if ({hsel_boot, hsel_io, hsel_ram} !== e_sel || hready !== e_rdy ||
        hresp !== e_rsp || hrdata !== e_dat) begin
      fails++;
      $display("FAIL %s addr=%h: sel/rdy/rsp/data actual %b %b %b %h expected %b %b %b %h",
               tag, a, {hsel_boot, hsel_io, hsel_ram}, hready, hresp, hrdata,
               e_sel, e_rdy, e_rsp, e_dat);
    end
    if (m_err == 1) nerr = 2;
    else if (e_rdy && t[1] && own == 3) nerr = 1;
    else nerr = 0;
    if (e_rdy) m_slot = t[1] ? own : 3;
    m_err = nerr;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    step(32'h0, 2'b00, 3'b111, 3'b000, "R1");
    // R2 / R6 RAM reads, R7 wait state holds slot
    step(32'h0000_0000, 2'b10, 3'b111, 3'b000, "R2");
    step(32'h0000_7FFC, 2'b11, 3'b111, 3'b000, "R2");
    step(32'h1FC0_0000, 2'b10, 3'b110, 3'b000, "R7");
    step(32'h1FC0_0000, 2'b10, 3'b110, 3'b000, "R7");
    step(32'h0000_0100, 2'b10, 3'b111, 3'b000, "R6");
    // R5 beyond RAM size, R9 error sequence
    step(32'h0000_8000, 2'b10, 3'b111, 3'b000, "R5");
    step(32'h0, 2'b00, 3'b111, 3'b000, "R9");
    step(32'h0, 2'b00, 3'b111, 3'b000, "R9");
    step(32'h1F7F_FFFC, 2'b00, 3'b111, 3'b000, "R5");
    // R3 GPIO window and its edge
    step(32'h1F80_0000, 2'b10, 3'b111, 3'b000, "R3");
    step(32'h1F80_0010, 2'b11, 3'b111, 3'b010, "R3");
    step(32'h1F80_0014, 2'b10, 3'b111, 3'b010, "R6");
    step(32'h0, 2'b00, 3'b111, 3'b000, "R9");
    step(32'h0, 2'b00, 3'b111, 3'b000, "R9");
    // R4 boot window and its edge
    step(32'h1FC0_0000, 2'b10, 3'b111, 3'b000, "R4");
    step(32'h1FC0_0FFC, 2'b11, 3'b011, 3'b000, "R4");
    step(32'h1FC0_1000, 2'b10, 3'b011, 3'b000, "R7");
    step(32'h1FC0_1000, 2'b10, 3'b111, 3'b100, "R4");
    step(32'h0, 2'b00, 3'b111, 3'b000, "R9");
    step(32'h0, 2'b00, 3'b111, 3'b000, "R9");
    // R8 idle/busy, also at unmapped address
    step(32'h1FC0_0000, 2'b01, 3'b111, 3'b000, "R8");
    step(32'h0000_8000, 2'b00, 3'b000, 3'b111, "R8");
    step(32'hFFFF_FFF0, 2'b00, 3'b111, 3'b000, "R8");
    // back-to-back: error then RAM accepted in second error cycle
    step(32'hFFFF_FFF0, 2'b10, 3'b111, 3'b000, "R9");
    step(32'h0000_0040, 2'b10, 3'b111, 3'b000, "R9");
    step(32'h0000_0040, 2'b10, 3'b111, 3'b000, "R9");
    step(32'h0, 2'b00, 3'b111, 3'b001, "R6");
    step(32'h0, 2'b00, 3'b111, 3'b000, "R8");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule